// File: doc/BRIEF.md
# SPI Frame Counter and Status Flags

This block keeps the frame count and the completion status of an SPI controller. The shift engine sends one strobe for each frame it finishes. With that strobe come two bits from the command word of that frame: one that marks the frame as the end of the queue and one that asks for the frame counter to be cleared. The block counts frames in a 16-bit counter that wraps. It also keeps two sticky flags, one for a finished frame and one for the end of the queue. A maskable interrupt output is driven from the two flags.

Software reaches the block through a single-cycle register port: a 2-bit address, a write strobe, write data and combinational read data. Select code 0 is the count register, with the counter in bits 31:16. Select code 1 is the status register and code 2 is the interrupt enable register. Both place the frame-done flag at bit 31 and the end-of-queue flag at bit 28. Status flags are cleared by writing one to their bit, so writing back a value just read clears exactly the flags that value showed.

Top module: `xfer_stat_regs`

## Requirements
- R1: After reset, every register reads zero and `irq` is 0. Reading select code 0 returns the counter in bits 31:16, with bits 15:0 always zero.
- R2: Each cycle with `frame_done` high and `frame_clr` low adds one to the counter. The new value is visible on the next cycle.
- R3: When a frame is counted with the counter at 65535, the counter becomes 0 and keeps counting from there.
- R4: A frame with `frame_done` and `frame_clr` both high clears the counter and then counts that frame, so the counter reads 1. `frame_clr` has no effect without `frame_done`.
- R5: Status (select code 1) holds the frame-done flag at bit 31 and reads zero in every bit other than 31 and 28. The frame-done flag sets on every `frame_done`.
- R6: The end-of-queue flag (status bit 28) sets only on a cycle with both `frame_done` and `frame_eoq` high.
- R7: Writing to status clears each flag whose bit is one in the write data. A flag whose bit is zero in the write data is left unchanged.
- R8: If a flag's set event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R9: The enable register (select code 2) stores only bits 31 and 28 and reads zero elsewhere. Select code 3 always reads zero.
- R10: `irq` is high exactly when some flag is set and its enable bit is set.
- R11: Writes to the count register do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_done | input | 1 | One-cycle strobe: a frame has been sent |
| frame_eoq | input | 1 | End-of-queue bit of that frame's command, qualified by frame_done |
| frame_clr | input | 1 | Counter-clear bit of that frame's command, qualified by frame_done |
| reg_addr | input | 2 | Register select: 0 count, 1 status, 2 enable, 3 none |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check three things. The counter steps by one per plain frame, reads 1 after a clearing frame and holds otherwise. A set event wins over a clear in the same cycle, and a clear without a set event empties its flag. The interrupt rises only after a frame or an enable write. Only the bench's scenarios can show the rest:
- the wrap from 65535 to 0, which needs a long run of frames;
- that writes to the count register change nothing;
- the read layout of each register, including the zero bits;
- that writing back a value just read clears exactly the flags that were set.

// File: rtl/xs_pkg.sv
package xs_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/xs_frame_counter.sv
module xs_frame_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic             frame_clr,
  output logic [CNT_W-1:0] cnt_q
);
  // next count: a clearing frame restarts from zero, then counts itself
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] cur,
                                                 input logic clr);
    logic [CNT_W-1:0] base;
    base = clr ? '0 : cur;
    return base + 1'b1;
  endfunction

  logic advance_evt;
  assign advance_evt = frame_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (advance_evt) cnt_q <= cnt_next(cnt_q, frame_clr);
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_clr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_clr) |=> (cnt_q == CNT_W'(1)));
  // R11
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cnt_q));
endmodule

// File: rtl/xs_status_flags.sv
module xs_status_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_done,
  input  logic frame_eoq,
  input  logic clr_tc,
  input  logic clr_eoq,
  output logic tc_q,
  output logic eoq_q
);
  logic set_tc, set_eoq;
  assign set_tc  = frame_done;
  assign set_eoq = frame_done && frame_eoq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q  <= 1'b0;
      eoq_q <= 1'b0;
    end else begin
      if (set_tc) tc_q <= 1'b1;
      else if (clr_tc) tc_q <= 1'b0;
      if (set_eoq) eoq_q <= 1'b1;
      else if (clr_eoq) eoq_q <= 1'b0;
    end
  end

  // R8
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> tc_q);
  // R8
  eoq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_eoq) |=> eoq_q);
  // R7
  tc_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tc && !frame_done) |=> !tc_q);
  // R6
  eoq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoq_q && !(frame_done && frame_eoq)) |=> !eoq_q);
endmodule

// File: rtl/xs_reg_port.sv
module xs_reg_port #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              tc_q,
  input  logic              eoq_q,
  output logic              clr_tc,
  output logic              clr_eoq,
  output logic              en_tc_q,
  output logic              en_eoq_q,
  output logic [DATA_W-1:0] reg_rdata
);
  import xs_pkg::*;
  localparam int TC_BIT  = DATA_W - 1;
  localparam int EOQ_BIT = DATA_W - 4;
  localparam int CNT_LSB = DATA_W - CNT_W;

  reg_sel_e sel;
  logic wr_status, wr_enable;
  assign sel       = reg_sel_e'(reg_addr);
  assign wr_status = reg_wr && (sel == SEL_STATUS);
  assign wr_enable = reg_wr && (sel == SEL_ENABLE);
  assign clr_tc    = wr_status && reg_wdata[TC_BIT];
  assign clr_eoq   = wr_status && reg_wdata[EOQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_tc_q  <= 1'b0;
      en_eoq_q <= 1'b0;
    end else if (wr_enable) begin
      en_tc_q  <= reg_wdata[TC_BIT];
      en_eoq_q <= reg_wdata[EOQ_BIT];
    end
  end

  function automatic logic [DATA_W-1:0] flag_word(input logic a, input logic b);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TC_BIT]  = a;
    w[EOQ_BIT] = b;
    return w;
  endfunction

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_COUNT:  reg_rdata[DATA_W-1:CNT_LSB] = cnt_q;
      SEL_STATUS: reg_rdata = flag_word(tc_q, eoq_q);
      SEL_ENABLE: reg_rdata = flag_word(en_tc_q, en_eoq_q);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xfer_stat_regs.sv
module xfer_stat_regs #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              frame_eoq,
  input  logic              frame_clr,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_q;
  logic tc_q, eoq_q, clr_tc, clr_eoq, en_tc_q, en_eoq_q;

  xs_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .frame_clr(frame_clr), .cnt_q(cnt_q));

  xs_status_flags u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_eoq(frame_eoq),
    .clr_tc(clr_tc), .clr_eoq(clr_eoq), .tc_q(tc_q), .eoq_q(eoq_q));

  xs_reg_port #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_port (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .cnt_q(cnt_q), .tc_q(tc_q), .eoq_q(eoq_q),
    .clr_tc(clr_tc), .clr_eoq(clr_eoq), .en_tc_q(en_tc_q),
    .en_eoq_q(en_eoq_q), .reg_rdata(reg_rdata));

  assign irq = (tc_q && en_tc_q) || (eoq_q && en_eoq_q);

  // R10
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(frame_done) || $past(reg_wr && reg_addr == 2'd2)));
endmodule

// File: tb/xfer_stat_regs_bench.sv
module xfer_stat_regs_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 1'b0, frame_eoq = 1'b0, frame_clr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int total = 0, bad = 0, cycles = 0;
  int m_cnt = 0;
  bit m_tc = 0, m_eoq = 0, m_en_tc = 0, m_en_eoq = 0;

  always #(PERIOD/2) clk = ~clk;

  xfer_stat_regs u_xfer_stat_regs (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_eoq(frame_eoq),
    .frame_clr(frame_clr), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      2'd0: v = 32'(m_cnt) << 16;
      2'd1: begin v[31] = m_tc; v[28] = m_eoq; end
      2'd2: begin v[31] = m_en_tc; v[28] = m_en_eoq; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, reg_rdata, model_read(reg_addr));
    check({tag, " irq (R10)"}, {31'd0, irq},
          {31'd0, (m_tc && m_en_tc) || (m_eoq && m_en_eoq)});
  endtask

  task automatic cyc(input logic fd, input logic eq, input logic cl, input logic wr,
                     input logic [1:0] a, input logic [31:0] wd, input string tag);
    @(negedge clk);
    frame_done = fd; frame_eoq = eq; frame_clr = cl;
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    // behavioural model of the next state
    if (fd) m_cnt = cl ? 1 : (m_cnt + 1) % 65536;
    if (fd) m_tc = 1;
    else if (wr && a == 2'd1 && wd[31]) m_tc = 0;
    if (fd && eq) m_eoq = 1;
    else if (wr && a == 2'd1 && wd[28]) m_eoq = 0;
    if (wr && a == 2'd2) begin m_en_tc = wd[31]; m_en_eoq = wd[28]; end
    #(PERIOD/4);
    compare(tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    cyc(0, 0, 0, 0, a, 32'h0, tag);
  endtask

  initial begin
    // R1 / R9: reset values
    reg_addr = 2'd0; #2; check("R1 count at reset", reg_rdata, 32'h0);
    reg_addr = 2'd1; #1; check("R1 status at reset", reg_rdata, 32'h0);
    reg_addr = 2'd2; #1; check("R9 enable at reset", reg_rdata, 32'h0);
    check("R1 irq at reset", {31'd0, irq}, 32'h0);
    #(PERIOD*2); rst_n = 1'b1;
    rd(2'd0, "R1 count after reset");

    // R2: plain frames, read count between them
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, 2'd0, 0, "R2 count step");
    cyc(1, 0, 0, 0, 2'd0, 0, "R2 count step");
    rd(2'd0, "R2 count idle");
    check("R2 six frames", reg_rdata, 32'h0006_0000);
    // R5 / R6: frame-done set, end-of-queue clear
    rd(2'd1, "R5 status after frames");
    check("R6 no eoq without flag", reg_rdata, 32'h8000_0000);
    cyc(1, 1, 0, 0, 2'd1, 0, "R6 eoq frame");
    check("R6 eoq set", reg_rdata, 32'h9000_0000);
    // eoq flag alone without frame_done has no effect
    cyc(0, 1, 0, 1, 2'd1, 32'h9000_0000, "R7 clear both");
    check("R7 both cleared", reg_rdata, 32'h0);
    cyc(0, 1, 0, 0, 2'd1, 0, "R6 eoq without frame");
    check("R6 eoq ignored without frame", reg_rdata, 32'h0);

    // R7: writing zero leaves flags, write back clears exactly read flags
    cyc(1, 1, 0, 0, 2'd1, 0, "R5 set both");
    cyc(0, 0, 0, 1, 2'd1, 32'h6FFF_FFFF, "R7 zero bits keep flags");
    check("R7 flags kept", reg_rdata, 32'h9000_0000);
    cyc(0, 0, 0, 1, 2'd1, 32'h1000_0000, "R7 clear eoq only");
    check("R7 tc kept", reg_rdata, 32'h8000_0000);
    cyc(0, 0, 0, 1, 2'd1, reg_rdata, "R7 write back");
    check("R7 write back clears", reg_rdata, 32'h0);

    // R8: set beats clear in the same cycle
    cyc(1, 1, 0, 1, 2'd1, 32'h9000_0000, "R8 set and clear");
    check("R8 set wins", reg_rdata, 32'h9000_0000);

    // R9 / R10: enable register and interrupt
    cyc(0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R9 enable all");
    check("R9 only two bits", reg_rdata, 32'h9000_0000);
    check("R10 irq on", {31'd0, irq}, 32'h1);
    rd(2'd3, "R9 unmapped");
    check("R9 unmapped zero", reg_rdata, 32'h0);
    cyc(0, 0, 0, 1, 2'd2, 32'h1000_0000, "R10 eoq enable only");
    cyc(0, 0, 0, 1, 2'd1, 32'h1000_0000, "R10 clear eoq");
    check("R10 tc set but masked", {31'd0, irq}, 32'h0);
    cyc(0, 0, 0, 1, 2'd2, 32'h8000_0000, "R10 tc enable");
    check("R10 irq from tc", {31'd0, irq}, 32'h1);
    cyc(0, 0, 0, 1, 2'd1, 32'h8000_0000, "R10 clear tc");
    check("R10 irq off", {31'd0, irq}, 32'h0);

    // R11: count register write ignored
    rd(2'd0, "R11 before write");
    cyc(0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF, "R11 count write");
    check("R11 count unchanged", reg_rdata, 32'h0009_0000);

    // R4: clear flag
    cyc(0, 0, 1, 0, 2'd0, 0, "R4 clear without frame");
    check("R4 ignored", reg_rdata, 32'h0009_0000);
    cyc(1, 0, 1, 0, 2'd0, 0, "R4 clearing frame");
    check("R4 reads one", reg_rdata, 32'h0001_0000);

    // R3: wrap
    for (int i = 0; i < 65534; i++) cyc(1, 0, 0, 0, 2'd0, 0, "R3 run up");
    check("R3 at max", reg_rdata, 32'hFFFF_0000);
    cyc(1, 0, 0, 0, 2'd0, 0, "R3 wrap");
    check("R3 wrapped", reg_rdata, 32'h0000_0000);
    cyc(1, 0, 0, 0, 2'd0, 0, "R3 after wrap");
    check("R3 keeps counting", reg_rdata, 32'h0001_0000);

    rd(2'd0, "R2 final");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule